// File: doc/BRIEF.md
# Branch Target Buffer with Combined Direction Prediction

This block sits beside the fetch stage and decides, for every fetch address, whether the next fetch should be redirected and to which address. It keeps a small fully associative table. Each entry records the address of a branch, a two-bit saturating confidence counter and the last known target of that branch. A lookup is purely combinational, so the decision is available in the same cycle as the fetch address.

A two-bit policy input chooses how a table hit or miss is combined with direction information:
- **Implicit:** a hit always redirects and a miss always continues inline.
- **Miss-fallback:** a hit always redirects, and a miss defers to an externally supplied direction guess and target.
- **Hit-counter:** a miss always continues inline, and a hit redirects only when the entry's own counter says taken.

Resolved branches arrive on a separate update port. Each update either trains an existing entry or allocates a new one, replacing entries in round-robin order.

Top module: `btb_predictor`

## Requirements
- R1: After reset the table holds no entries, so `lookupHit` is 0 for every fetch address until a taken update has been accepted.
- R2: `lookupHit` is 1 exactly when `fetchAddr` equals the branch address of a stored entry. On a hit, `redirectTarget` equals that entry's stored target. On a miss, `redirectTarget` equals `fallbackTarget`.
- R3: With `policySel` = 0 (implicit), `redirect` equals `lookupHit`.
- R4: With `policySel` = 1 (miss-fallback), `redirect` is 1 on a hit. On a miss, `redirect` equals `fallbackTaken`.
- R5: With `policySel` = 2 (hit-counter), `redirect` is 0 on a miss. On a hit, `redirect` is 1 exactly when the entry's counter is 2 or 3.
- R6: `policySel` = 3 behaves identically to `policySel` = 0.
- R7: An update with `updValid`=1 and `updTaken`=1 whose address is not stored allocates an entry. The new entry holds that address, `updTarget`, and a counter value of 2.
- R8: An update with `updTaken`=0 whose address is not stored changes nothing: a later lookup of that address still misses.
- R9: An update whose address is stored moves that entry's counter up by one if taken, or down by one if not taken. The counter saturates at 3 and at 0.
- R10: A taken update that hits replaces the stored target with `updTarget`. A not-taken update leaves the stored target unchanged.
- R11: Allocation uses a round-robin victim pointer. When all 16 entries are in use, the next allocation evicts the entry that was allocated earliest.
- R12: An update becomes visible to lookups on the cycle after it is presented. A lookup in the same cycle as the update sees the old table contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetchAddr | input | 32 | Address being fetched this cycle |
| policySel | input | 2 | 0 implicit, 1 miss-fallback, 2 hit-counter, 3 same as 0 |
| fallbackTaken | input | 1 | External direction guess used on a miss under policy 1 |
| fallbackTarget | input | 32 | Target used when a miss redirects |
| updValid | input | 1 | A resolved branch is presented |
| updAddr | input | 32 | Address of the resolved branch |
| updTaken | input | 1 | Resolved direction (1 = taken) |
| updTarget | input | 32 | Resolved target address |
| lookupHit | output | 1 | `fetchAddr` matches a stored entry |
| redirect | output | 1 | Fetch should go to `redirectTarget` next |
| redirectTarget | output | 32 | Stored target on a hit, `fallbackTarget` on a miss |

## Verification
The three lookup outputs are combinational, so they are due in the same cycle as the fetch address and policy that produce them. An update is due one clock edge after it is presented.

The bench drives every input just after a falling edge and compares the outputs 2 ns later against a behavioural model. It applies that cycle's update to the model only after the following rising edge. This way, a lookup that shares a cycle with an update is checked against the old contents, and the next cycle is checked against the new contents.

The model is an allocation-ordered queue, so round-robin eviction appears as the queue dropping its oldest element.

// File: rtl/btb_pkg.sv
package btb_pkg;

  localparam int CNT_W = 2;
  localparam logic [CNT_W-1:0] CNT_ALLOC = 2'd2;
  localparam logic [CNT_W-1:0] CNT_MAX   = 2'd3;

  typedef enum logic [1:0] {
    POL_IMPLICIT      = 2'd0,
    POL_MISS_FALLBACK = 2'd1,
    POL_HIT_COUNTER   = 2'd2,
    POL_ALIAS_IMPL    = 2'd3
  } policy_e;

  // Strobes from control to datapath for one table write
  typedef struct packed {
    logic             wrEn;
    logic             alloc;
    logic             wrTarget;
    logic [CNT_W-1:0] newCnt;
  } btbStrobe_t;

endpackage

// File: rtl/btb_datapath.sv
module btb_datapath
  import btb_pkg::*;
#(
  parameter int AW      = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    fetchAddr,
  input  logic [AW-1:0]    fallbackTarget,
  input  logic [AW-1:0]    updAddr,
  input  logic [AW-1:0]    updTarget,
  input  btbStrobe_t       strb,
  input  logic [IDX_W-1:0] wrIdx,
  output logic             lkHit,
  output logic [CNT_W-1:0] lkCnt,
  output logic [AW-1:0]    lkTarget,
  output logic             upHit,
  output logic [IDX_W-1:0] upIdx,
  output logic [CNT_W-1:0] upCnt,
  output logic             upTgtSame
);

  logic [ENTRIES-1:0] validQ;
  logic [AW-1:0]      tagQ [ENTRIES];
  logic [AW-1:0]      tgtQ [ENTRIES];
  logic [CNT_W-1:0]   cntQ [ENTRIES];

  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] upMatch;
  logic [IDX_W-1:0]   lkSel;

  // Per-entry comparators for the fetch port and the update port
  for (genvar g = 0; g < ENTRIES; g++) begin : gMatch
    assign lkMatch[g] = validQ[g] && (tagQ[g] == fetchAddr);
    assign upMatch[g] = validQ[g] && (tagQ[g] == updAddr);
  end

  // Lowest matching index wins (duplicates never arise)
  always_comb begin
    lkHit = 1'b0;
    lkSel = '0;
    upHit = 1'b0;
    upIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (lkMatch[i]) begin
        lkHit = 1'b1;
        lkSel = IDX_W'(i);
      end
      if (upMatch[i]) begin
        upHit = 1'b1;
        upIdx = IDX_W'(i);
      end
    end
  end

  assign lkCnt     = cntQ[lkSel];
  assign lkTarget  = lkHit ? tgtQ[lkSel] : fallbackTarget;
  assign upCnt     = cntQ[upIdx];
  assign upTgtSame = (tgtQ[upIdx] == updTarget);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      validQ <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tagQ[i] <= '0;
        tgtQ[i] <= '0;
        cntQ[i] <= '0;
      end
    end else if (strb.wrEn) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (wrIdx == IDX_W'(i)) begin
          cntQ[i] <= strb.newCnt;
          if (strb.alloc) begin
            validQ[i] <= 1'b1;
            tagQ[i]   <= updAddr;
            tgtQ[i]   <= updTarget;
          end else if (strb.wrTarget) begin
            tgtQ[i] <= updTarget;
          end
        end
      end
    end
  end

endmodule

// File: rtl/btb_control.sv
module btb_control
  import btb_pkg::*;
#(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       policySel,
  input  logic             fallbackTaken,
  input  logic             lkHit,
  input  logic [CNT_W-1:0] lkCnt,
  input  logic             updValid,
  input  logic             updTaken,
  input  logic             upHit,
  input  logic [IDX_W-1:0] upIdx,
  input  logic [CNT_W-1:0] upCnt,
  input  logic             upTgtSame,
  output btbStrobe_t       strb,
  output logic [IDX_W-1:0] wrIdx,
  output logic             redirect
);

  logic [IDX_W-1:0] rrPtr;
  policy_e          pol;

  assign pol = policy_e'(policySel);

  // Next-fetch decision
  always_comb begin
    unique case (pol)
      POL_MISS_FALLBACK: redirect = lkHit | fallbackTaken;
      POL_HIT_COUNTER:   redirect = lkHit & lkCnt[CNT_W-1];
      default:           redirect = lkHit;
    endcase
  end

  // Training and allocation strobes
  always_comb begin
    strb  = '0;
    wrIdx = upIdx;
    if (updValid) begin
      if (upHit) begin
        strb.wrEn     = 1'b1;
        strb.wrTarget = updTaken && !upTgtSame;
        if (updTaken)
          strb.newCnt = (upCnt == CNT_MAX) ? upCnt : upCnt + 1'b1;
        else
          strb.newCnt = (upCnt == '0) ? upCnt : upCnt - 1'b1;
      end else if (updTaken) begin
        strb.wrEn   = 1'b1;
        strb.alloc  = 1'b1;
        strb.newCnt = CNT_ALLOC;
        wrIdx       = rrPtr;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rrPtr <= '0;
    else if (strb.alloc)
      rrPtr <= (rrPtr == IDX_W'(ENTRIES - 1)) ? '0 : rrPtr + 1'b1;
  end

endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
  import btb_pkg::*;
#(
  parameter int AW      = 32,
  parameter int ENTRIES = 16,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] fetchAddr,
  input  logic [1:0]    policySel,
  input  logic          fallbackTaken,
  input  logic [AW-1:0] fallbackTarget,
  input  logic          updValid,
  input  logic [AW-1:0] updAddr,
  input  logic          updTaken,
  input  logic [AW-1:0] updTarget,
  output logic          lookupHit,
  output logic          redirect,
  output logic [AW-1:0] redirectTarget
);

  btbStrobe_t       strb;
  logic [IDX_W-1:0] wrIdx;
  logic [CNT_W-1:0] lkCnt;
  logic             upHit;
  logic [IDX_W-1:0] upIdx;
  logic [CNT_W-1:0] upCnt;
  logic             upTgtSame;

  btb_datapath #(.AW(AW), .ENTRIES(ENTRIES)) u_dp (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetchAddr      (fetchAddr),
    .fallbackTarget (fallbackTarget),
    .updAddr        (updAddr),
    .updTarget      (updTarget),
    .strb           (strb),
    .wrIdx          (wrIdx),
    .lkHit          (lookupHit),
    .lkCnt          (lkCnt),
    .lkTarget       (redirectTarget),
    .upHit          (upHit),
    .upIdx          (upIdx),
    .upCnt          (upCnt),
    .upTgtSame      (upTgtSame)
  );

  btb_control #(.ENTRIES(ENTRIES)) u_ctl (
    .clk           (clk),
    .rst_n         (rst_n),
    .policySel     (policySel),
    .fallbackTaken (fallbackTaken),
    .lkHit         (lookupHit),
    .lkCnt         (lkCnt),
    .updValid      (updValid),
    .updTaken      (updTaken),
    .upHit         (upHit),
    .upIdx         (upIdx),
    .upCnt         (upCnt),
    .upTgtSame     (upTgtSame),
    .strb          (strb),
    .wrIdx         (wrIdx),
    .redirect      (redirect)
  );

endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk
  import btb_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] fetchAddr,
  input logic [1:0]    policySel,
  input logic          fallbackTaken,
  input logic          updValid,
  input logic [AW-1:0] updAddr,
  input logic          updTaken,
  input logic          lookupHit,
  input logic          redirect,
  input btbStrobe_t    strb
);

  logic primed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  // R3 and R6: implicit policies follow the hit flag
  p_implicit_follows_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (policySel == 2'd0 || policySel == 2'd3) |-> (redirect == lookupHit));

  // R4: a miss under miss-fallback defers to the external guess
  p_miss_uses_fallback_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (policySel == 2'd1 && !lookupHit) |-> (redirect == fallbackTaken));

  // R4: a hit under miss-fallback always redirects
  p_hit_redirects_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (policySel == 2'd1 && lookupHit) |-> redirect);

  // R5: a miss under hit-counter stays inline
  p_miss_inline_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (policySel == 2'd2 && !lookupHit) |-> !redirect);

  // R8: allocation happens only for a presented taken branch
  p_alloc_needs_taken_r8: assert property (@(posedge clk) disable iff (!rst_n)
    strb.alloc |-> (updValid && updTaken && strb.wrEn));

  // R12: a taken update is visible to a lookup of its address next cycle
  p_update_visible_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(updValid && updTaken) && fetchAddr == $past(updAddr)) |-> lookupHit);

endmodule

bind btb_predictor btb_predictor_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetchAddr     (fetchAddr),
  .policySel     (policySel),
  .fallbackTaken (fallbackTaken),
  .updValid      (updValid),
  .updAddr       (updAddr),
  .updTaken      (updTaken),
  .lookupHit     (lookupHit),
  .redirect      (redirect),
  .strb          (strb)
);

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetchAddr = '0;
  logic [1:0]  policySel = '0;
  logic        fallbackTaken = 1'b0;
  logic [31:0] fallbackTarget = '0;
  logic        updValid = 1'b0;
  logic [31:0] updAddr = '0;
  logic        updTaken = 1'b0;
  logic [31:0] updTarget = '0;
  logic        lookupHit;
  logic        redirect;
  logic [31:0] redirectTarget;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;  // 50 MHz

  btb_predictor dut (
    .clk(clk), .rst_n(rst_n), .fetchAddr(fetchAddr), .policySel(policySel),
    .fallbackTaken(fallbackTaken), .fallbackTarget(fallbackTarget),
    .updValid(updValid), .updAddr(updAddr), .updTaken(updTaken),
    .updTarget(updTarget), .lookupHit(lookupHit), .redirect(redirect),
    .redirectTarget(redirectTarget)
  );

  // Behavioural model: entries kept in allocation order
  typedef struct {
    logic [31:0] addr;
    logic [31:0] tgt;
    int          cnt;
  } ent_t;
  ent_t mq[$];

  function automatic int mFind(logic [31:0] a);
    foreach (mq[k]) if (mq[k].addr == a) return k;
    return -1;
  endfunction

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(logic [1:0] pol, logic [31:0] fa, logic fbT, logic [31:0] fbTgt,
                      logic uv, logic [31:0] ua, logic ut, logic [31:0] utg, string tag);
    int k;
    logic eHit, eRed;
    logic [31:0] eTgt;
    @(negedge clk);
    policySel = pol; fetchAddr = fa; fallbackTaken = fbT; fallbackTarget = fbTgt;
    updValid = uv; updAddr = ua; updTaken = ut; updTarget = utg;
    #2;
    k    = mFind(fa);
    eHit = (k >= 0);
    eTgt = eHit ? mq[k].tgt : fbTgt;
    case (pol)
      2'd1:    eRed = eHit | fbT;
      2'd2:    eRed = eHit && (mq[k].cnt >= 2);
      default: eRed = eHit;
    endcase
    check(tag, "lookupHit", {31'b0, lookupHit}, {31'b0, eHit});
    check(tag, "redirect", {31'b0, redirect}, {31'b0, eRed});
    check(tag, "redirectTarget", redirectTarget, eTgt);
    @(posedge clk);
    if (uv) begin
      k = mFind(ua);
      if (k >= 0) begin
        if (ut) begin
          if (mq[k].cnt < 3) mq[k].cnt++;
          mq[k].tgt = utg;
        end else if (mq[k].cnt > 0) mq[k].cnt--;
      end else if (ut) begin
        if (mq.size() == 16) void'(mq.pop_front());
        mq.push_back('{ua, utg, 2});
      end
    end
  endtask

  task automatic look(logic [1:0] pol, logic [31:0] fa, logic fbT, string tag);
    step(pol, fa, fbT, 32'hF0F0_0000, 1'b0, 32'h0, 1'b0, 32'h0, tag);
  endtask

  task automatic upd(logic [31:0] ua, logic ut, logic [31:0] utg, string tag);
    step(2'd0, 32'h0, 1'b0, 32'h0, 1'b1, ua, ut, utg, tag);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: empty after reset
    look(2'd0, 32'h0000_0100, 1'b0, "R1");
    look(2'd0, 32'h0000_0000, 1'b0, "R1");
    // R4: miss under miss-fallback follows the external guess
    look(2'd1, 32'h0000_0100, 1'b1, "R4");
    look(2'd1, 32'h0000_0100, 1'b0, "R4");

    // R12: taken update with same-cycle lookup of that address sees old state
    step(2'd0, 32'h0000_0100, 1'b0, 32'h0, 1'b1, 32'h0000_0100, 1'b1, 32'h0000_2000, "R12");
    // R7: new entry hits next cycle with counter 2 (hit-counter redirects)
    look(2'd2, 32'h0000_0100, 1'b0, "R7");
    look(2'd0, 32'h0000_0100, 1'b0, "R2");

    // R8: not-taken miss allocates nothing
    upd(32'h0000_0200, 1'b0, 32'h0000_3000, "R8");
    look(2'd0, 32'h0000_0200, 1'b0, "R8");
    look(2'd1, 32'h0000_0200, 1'b1, "R8");

    // R9: count down to and saturate at 0
    upd(32'h0000_0100, 1'b0, 32'h0, "R9");
    look(2'd2, 32'h0000_0100, 1'b0, "R9");
    upd(32'h0000_0100, 1'b0, 32'h0, "R9");
    upd(32'h0000_0100, 1'b0, 32'h0, "R9");
    look(2'd2, 32'h0000_0100, 1'b0, "R9");
    // R10: not-taken keeps the target
    look(2'd0, 32'h0000_0100, 1'b0, "R10");
    // R5: weak counter hit stays inline; miss stays inline
    look(2'd2, 32'h0000_0100, 1'b0, "R5");
    look(2'd2, 32'h0000_0500, 1'b1, "R5");
    // R9: count up and saturate at 3
    for (int i = 0; i < 5; i++) upd(32'h0000_0100, 1'b1, 32'h0000_2000, "R9");
    look(2'd2, 32'h0000_0100, 1'b0, "R9");
    upd(32'h0000_0100, 1'b0, 32'h0, "R9");
    look(2'd2, 32'h0000_0100, 1'b0, "R9");

    // R10: taken hit with a new target replaces it
    upd(32'h0000_0100, 1'b1, 32'h0000_4444, "R10");
    look(2'd0, 32'h0000_0100, 1'b0, "R10");

    // R3, R4, R6: policies on a hit and a miss
    look(2'd0, 32'h0000_0100, 1'b1, "R3");
    look(2'd0, 32'h0000_0700, 1'b1, "R3");
    look(2'd1, 32'h0000_0100, 1'b0, "R4");
    look(2'd3, 32'h0000_0100, 1'b0, "R6");
    look(2'd3, 32'h0000_0700, 1'b1, "R6");

    // R11: fill the table, then one more allocation evicts the oldest
    for (int i = 1; i < 16; i++) upd(32'h0001_0000 + 32'(i * 4), 1'b1, 32'h0002_0000 + 32'(i), "R11");
    look(2'd0, 32'h0000_0100, 1'b0, "R11");
    upd(32'h0003_0000, 1'b1, 32'h0000_9999, "R11");
    look(2'd0, 32'h0000_0100, 1'b0, "R11");
    look(2'd0, 32'h0001_0004, 1'b0, "R11");
    look(2'd0, 32'h0003_0000, 1'b0, "R11");

    // R2, R12: random mix on a small address space
    for (int i = 0; i < 600; i++) begin
      step(2'($urandom_range(0, 3)), 32'($urandom_range(0, 23) * 4), 1'($urandom_range(0, 1)),
           32'($urandom), 1'($urandom_range(0, 1)), 32'($urandom_range(0, 23) * 4),
           1'($urandom_range(0, 1)), 32'($urandom_range(0, 3) * 16), "R2");
    end

    finish_run();
  end

endmodule